// File: doc/BRIEF.md
# Virtual Error Syndrome Register Unit

This block holds the syndrome that a hypervisor prepares for a virtual system-error interrupt aimed at level 1. Software reaches it through a system-register port with separate read and write strobes. The port also carries the current exception level (0 to 3), a level-2-enabled flag and two nested-virtualisation control bits. The unit resolves each access in the same cycle as its strobe, and every access ends in exactly one outcome. It either completes against the register, is sent to a fixed memory offset for the hypervisor's backing page, traps to level 2 with a class code, or is marked undefined.

When the guest takes the virtual error, or defers it with an error-barrier instruction, the unit registers a formatted copy of the stored fields onto one of three result ports, each with a one-cycle valid pulse. The three ports are a 64-bit-layout exception syndrome, a 32-bit-layout fault status, and a deferred-interrupt status. A static input picks the field layout, according to whether level 1 runs in 32-bit mode. Writes drop every reserved bit, so reserved bits read back as zero. The low word is also visible on a 32-bit alias output that shares the same storage.

The data flops have no reset; their value is unknown until the first write.

Top module: `virt_err_syndrome`

## Requirements
- R1: Any read or write strobe with level 0 on the level input asserts only the undefined outcome.
- R2: At levels 2 and 3 with both extension parameters enabled, an access completes against the register. A read drives the stored value on the read data in the strobe cycle. A write updates the storage at the next clock edge.
- R3: At level 1, with level 2 enabled and both nested-virtualisation bits set, the access asserts the redirect outcome and drives offset 0x508.
- R4: At level 1, with level 2 enabled, the plain nested bit set and the memory bit clear, the access asserts the trap outcome with class code 0x18.
- R5: Every other level-1 access (level 2 disabled, or the plain nested bit clear) is undefined.
- R6: Each strobe cycle asserts exactly one of ok, redirect, trap and undefined, and none is asserted without a strobe. A write whose outcome is not ok leaves the storage unchanged.
- R7: In 64-bit layout (narrow input 0), writes keep bit 24 (IDS) and bits 23:0 (ISS); bits 63:25 read as zero.
- R8: In 32-bit layout (narrow input 1), writes keep bits 15:14 (AET) and bit 12 (ExT); all other bits read as zero.
- R9: The alias output always equals bits 31:0 of the storage.
- R10: A take in 64-bit layout loads bits 24:0 of the storage onto the exception syndrome, with its valid high in the following cycle and the fault status valid low.
- R11: A take in 32-bit layout loads AET into bits 15:14 and ExT into bit 12 of the fault status, with its valid high in the following cycle and the exception syndrome valid low.
- R12: A deferral loads the stored fields, at their stored bit positions, onto the deferred status, with its valid high in the following cycle.
- R13: With the error-extension parameter off, every access is undefined. With the level-2 parameter off, a level-3 read completes with zero data, and level-1 and level-2 accesses are undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for control and valid flops |
| acc_rd | input | 1 | Register read strobe |
| acc_wr | input | 1 | Register write strobe |
| acc_wdata | input | REG_W | Write data |
| cur_el | input | 2 | Current exception level |
| el2_en | input | 1 | Level 2 enabled in the current security state |
| nv_ctl | input | 1 | Nested-virtualisation enable bit |
| nv_mem | input | 1 | Nested-virtualisation redirect-to-memory bit |
| el1_narrow | input | 1 | Level 1 uses 32-bit layout (static) |
| verr_take | input | 1 | Virtual error taken at level 1 |
| verr_defer | input | 1 | Virtual error deferred by barrier |
| acc_rdata | output | REG_W | Read data (zero unless ok read) |
| acc_ok | output | 1 | Access completed at the register |
| acc_redirect | output | 1 | Access redirected to memory |
| acc_redir_off | output | OFF_W | Memory offset of the redirect |
| acc_trap | output | 1 | Access traps to level 2 |
| acc_trap_class | output | EC_W | Trap class code |
| acc_undef | output | 1 | Access is undefined |
| alias_rdata | output | 32 | 32-bit alias view of the low word |
| esr_syn | output | 64 | 64-bit-layout exception syndrome |
| esr_vld | output | 1 | Exception syndrome loaded |
| fsr_syn | output | 32 | 32-bit-layout fault status |
| fsr_vld | output | 1 | Fault status loaded |
| dfr_syn | output | 64 | Deferred-interrupt status |
| dfr_vld | output | 1 | Deferred status loaded |

## Verification
The hardest case to reach is a write that looks legal but is diverted, by the redirect or the trap path, and must not touch storage. Its effect cannot be seen at the strobe. The stimulus first writes a known pattern from level 2. It then issues a level-1 write of a different pattern under each nested setting and reads back from level 2 afterwards. The two extension parameters are exercised by two extra instances that share the stimulus of the main one.

// File: rtl/ves_pkg.sv
package ves_pkg;

   localparam int IDS_BIT = 24;
   localparam int AET_HI  = 15;
   localparam int AET_LO  = 14;
   localparam int EXT_BIT = 12;

   typedef enum logic [2:0] {
      OUT_NONE,
      OUT_DIRECT,
      OUT_ZERO,
      OUT_REDIR,
      OUT_TRAP,
      OUT_UNDEF
   } acc_out_e;

   function automatic logic [63:0] field_mask(input logic narrow);
      logic [63:0] m;
      m = '0;
      if (narrow) begin
         m[AET_HI:AET_LO] = 2'b11;
         m[EXT_BIT]       = 1'b1;
      end else begin
         m[IDS_BIT:0]     = '1;
      end
      return m;
   endfunction

endpackage

// File: rtl/ves_acc_decode.sv
module ves_acc_decode
   import ves_pkg::*;
#(
   parameter bit HAS_RAS = 1'b1,
   parameter bit HAS_EL2 = 1'b1
) (
   input  logic     strobe,
   input  logic [1:0] cur_el,
   input  logic     el2_en,
   input  logic     nv_ctl,
   input  logic     nv_mem,
   output acc_out_e outcome
);

   logic     el2_live;
   acc_out_e base;

   assign el2_live = HAS_EL2 && el2_en;

   always_comb begin
      base = OUT_UNDEF;
      unique case (cur_el)
         2'd0: base = OUT_UNDEF;
         2'd1: begin
            if (el2_live && nv_ctl && nv_mem)
               base = OUT_REDIR;
            else if (el2_live && nv_ctl)
               base = OUT_TRAP;
            else
               base = OUT_UNDEF;
         end
         2'd2: base = HAS_EL2 ? OUT_DIRECT : OUT_UNDEF;
         2'd3: base = HAS_EL2 ? OUT_DIRECT : OUT_ZERO;
         default: base = OUT_UNDEF;
      endcase
   end

   generate
      if (HAS_RAS) begin : g_present
         assign outcome = strobe ? base : OUT_NONE;
      end else begin : g_absent
         assign outcome = strobe ? OUT_UNDEF : OUT_NONE;
      end
   endgenerate

endmodule

// File: rtl/ves_store.sv
module ves_store
   import ves_pkg::*;
#(
   parameter int REG_W = 64
) (
   input  logic             clk,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   input  logic             narrow,
   output logic [REG_W-1:0] q
);

   logic [63:0]      mask_full;
   logic [REG_W-1:0] mask;
   logic [REG_W-1:0] q_r;

   assign mask_full = field_mask(narrow);
   assign mask      = mask_full[REG_W-1:0];

   // Data flops deliberately carry no reset: contents are unknown until written.
   always_ff @(posedge clk) begin
      if (we)
         q_r <= wdata & mask;
   end

   assign q = q_r;

endmodule

// File: rtl/ves_syn_fmt.sv
module ves_syn_fmt
   import ves_pkg::*;
#(
   parameter int REG_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  logic             defer,
   input  logic             narrow,
   input  logic [REG_W-1:0] q,
   output logic [63:0]      esr_syn,
   output logic             esr_vld,
   output logic [31:0]      fsr_syn,
   output logic             fsr_vld,
   output logic [63:0]      dfr_syn,
   output logic             dfr_vld
);

   logic [63:0] esr_next;
   logic [31:0] fsr_next;
   logic [63:0] dfr_next;

   always_comb begin
      esr_next                  = '0;
      esr_next[IDS_BIT:0]       = q[IDS_BIT:0];
      fsr_next                  = '0;
      fsr_next[AET_HI:AET_LO]   = q[AET_HI:AET_LO];
      fsr_next[EXT_BIT]         = q[EXT_BIT];
      dfr_next                  = '0;
      dfr_next[REG_W-1:0]       = q;
   end

   always_ff @(posedge clk) begin
      if (take && !narrow) esr_syn <= esr_next;
      if (take &&  narrow) fsr_syn <= fsr_next;
      if (defer)           dfr_syn <= dfr_next;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         esr_vld <= 1'b0;
         fsr_vld <= 1'b0;
         dfr_vld <= 1'b0;
      end else begin
         esr_vld <= take && !narrow;
         fsr_vld <= take &&  narrow;
         dfr_vld <= defer;
      end
   end

endmodule

// File: rtl/virt_err_syndrome.sv
module virt_err_syndrome
   import ves_pkg::*;
#(
   parameter bit          HAS_RAS   = 1'b1,
   parameter bit          HAS_EL2   = 1'b1,
   parameter int          REG_W     = 64,
   parameter int          OFF_W     = 12,
   parameter int          EC_W      = 6,
   parameter logic [11:0] REDIR_OFF = 12'h508,
   parameter logic [5:0]  TRAP_EC   = 6'h18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_rd,
   input  logic             acc_wr,
   input  logic [REG_W-1:0] acc_wdata,
   input  logic [1:0]       cur_el,
   input  logic             el2_en,
   input  logic             nv_ctl,
   input  logic             nv_mem,
   input  logic             el1_narrow,
   input  logic             verr_take,
   input  logic             verr_defer,
   output logic [REG_W-1:0] acc_rdata,
   output logic             acc_ok,
   output logic             acc_redirect,
   output logic [OFF_W-1:0] acc_redir_off,
   output logic             acc_trap,
   output logic [EC_W-1:0]  acc_trap_class,
   output logic             acc_undef,
   output logic [31:0]      alias_rdata,
   output logic [63:0]      esr_syn,
   output logic             esr_vld,
   output logic [31:0]      fsr_syn,
   output logic             fsr_vld,
   output logic [63:0]      dfr_syn,
   output logic             dfr_vld
);

   localparam int OFF_PAD = (OFF_W > 12) ? OFF_W : 12;
   localparam int EC_PAD  = (EC_W > 6) ? EC_W : 6;

   generate
      if (REG_W < 32 || REG_W > 64) begin : g_bad_width
         $error("REG_W must lie in 32..64");
      end
      if (OFF_W < 12) begin : g_bad_off
         $error("OFF_W must be at least 12");
      end
      if (EC_W < 6) begin : g_bad_ec
         $error("EC_W must be at least 6");
      end
   endgenerate

   acc_out_e         outcome;
   logic [REG_W-1:0] q;
   logic             store_we;
   logic [OFF_PAD-1:0] off_ext;
   logic [EC_PAD-1:0]  ec_ext;

   ves_acc_decode #(
      .HAS_RAS(HAS_RAS),
      .HAS_EL2(HAS_EL2)
   ) u_dec (
      .strobe (acc_rd | acc_wr),
      .cur_el (cur_el),
      .el2_en (el2_en),
      .nv_ctl (nv_ctl),
      .nv_mem (nv_mem),
      .outcome(outcome)
   );

   assign store_we = acc_wr && (outcome == OUT_DIRECT);

   ves_store #(.REG_W(REG_W)) u_store (
      .clk   (clk),
      .we    (store_we),
      .wdata (acc_wdata),
      .narrow(el1_narrow),
      .q     (q)
   );

   ves_syn_fmt #(.REG_W(REG_W)) u_fmt (
      .clk    (clk),
      .rst_n  (rst_n),
      .take   (verr_take),
      .defer  (verr_defer),
      .narrow (el1_narrow),
      .q      (q),
      .esr_syn(esr_syn),
      .esr_vld(esr_vld),
      .fsr_syn(fsr_syn),
      .fsr_vld(fsr_vld),
      .dfr_syn(dfr_syn),
      .dfr_vld(dfr_vld)
   );

   assign off_ext = OFF_PAD'(REDIR_OFF);
   assign ec_ext  = EC_PAD'(TRAP_EC);

   assign acc_ok         = (outcome == OUT_DIRECT) || (outcome == OUT_ZERO);
   assign acc_redirect   = (outcome == OUT_REDIR);
   assign acc_trap       = (outcome == OUT_TRAP);
   assign acc_undef      = (outcome == OUT_UNDEF);
   assign acc_redir_off  = acc_redirect ? off_ext[OFF_W-1:0] : '0;
   assign acc_trap_class = acc_trap ? ec_ext[EC_W-1:0] : '0;
   assign acc_rdata      = (acc_rd && outcome == OUT_DIRECT) ? q : '0;
   assign alias_rdata    = q[31:0];

endmodule

// File: rtl/ves_chk.sv
module ves_chk #(
   parameter int REG_W = 64,
   parameter int OFF_W = 12,
   parameter int EC_W  = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_rd,
   input logic             acc_wr,
   input logic [1:0]       cur_el,
   input logic             el1_narrow,
   input logic             verr_take,
   input logic             verr_defer,
   input logic [REG_W-1:0] acc_rdata,
   input logic             acc_ok,
   input logic             acc_redirect,
   input logic [OFF_W-1:0] acc_redir_off,
   input logic             acc_trap,
   input logic [EC_W-1:0]  acc_trap_class,
   input logic             acc_undef,
   input logic [31:0]      alias_rdata,
   input logic             esr_vld,
   input logic             fsr_vld,
   input logic             dfr_vld
);

   logic [63:0] keep;
   assign keep = el1_narrow ? 64'h0000_0000_0000_D000 : 64'h0000_0000_01FF_FFFF;

   AST_EL0_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_rd || acc_wr) && cur_el == 2'd0) |-> acc_undef);  // R1
   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd || acc_wr) |-> $countones({acc_ok, acc_redirect, acc_trap, acc_undef}) == 1);  // R6
   AST_NO_IDLE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_rd || acc_wr) |-> !(acc_ok || acc_redirect || acc_trap || acc_undef));  // R6
   AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc_wr && acc_ok) |=> $stable(alias_rdata));  // R6
   AST_REDIR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      acc_redirect |-> acc_redir_off == OFF_W'(12'h508));  // R3
   AST_TRAP_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      acc_trap |-> (acc_trap_class == EC_W'(6'h18) && cur_el == 2'd1));  // R4
   AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && acc_ok) |-> (64'(acc_rdata) & ~keep) == 64'd0);  // R7
   AST_ALIAS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && acc_ok && cur_el == 2'd2) |-> alias_rdata == acc_rdata[31:0]);  // R9
   AST_TAKE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
      (verr_take && !el1_narrow) |=> (esr_vld && !fsr_vld));  // R10
   AST_TAKE_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
      (verr_take && el1_narrow) |=> (fsr_vld && !esr_vld));  // R11
   AST_DEFER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      verr_defer |=> dfr_vld);  // R12

endmodule

bind virt_err_syndrome ves_chk #(.REG_W(REG_W), .OFF_W(OFF_W), .EC_W(EC_W)) u_chk (.*);

// File: tb/virt_err_syndrome_test.sv
module virt_err_syndrome_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_rd = 0, acc_wr = 0;
   logic [63:0] acc_wdata = '0;
   logic [1:0]  cur_el = '0;
   logic        el2_en = 0, nv_ctl = 0, nv_mem = 0, el1_narrow = 0;
   logic        verr_take = 0, verr_defer = 0;

   logic [63:0] rdata;  logic ok, red, trp, und;
   logic [11:0] roff;   logic [5:0] tcls;
   logic [31:0] alias_q;
   logic [63:0] esr;    logic esr_v;
   logic [31:0] fsr;    logic fsr_v;
   logic [63:0] dfr;    logic dfr_v;

   logic [63:0] b_rdata; logic b_ok, b_red, b_trp, b_und;
   logic [11:0] b_roff;  logic [5:0] b_tcls; logic [31:0] b_alias;
   logic [63:0] b_esr, b_dfr; logic [31:0] b_fsr; logic b_esr_v, b_fsr_v, b_dfr_v;

   logic [63:0] c_rdata; logic c_ok, c_red, c_trp, c_und;
   logic [11:0] c_roff;  logic [5:0] c_tcls; logic [31:0] c_alias;
   logic [63:0] c_esr, c_dfr; logic [31:0] c_fsr; logic c_esr_v, c_fsr_v, c_dfr_v;

   int checks = 0;
   int fails  = 0;

   // sampled outcomes
   logic [63:0] s_rdata; logic [3:0] s_out; logic [11:0] s_off; logic [5:0] s_cls;
   logic [63:0] s_b_rdata; logic [3:0] s_b_out;
   logic [3:0]  s_c_out;

   always #4 clk = ~clk;

   virt_err_syndrome uut (
      .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
      .cur_el(cur_el), .el2_en(el2_en), .nv_ctl(nv_ctl), .nv_mem(nv_mem),
      .el1_narrow(el1_narrow), .verr_take(verr_take), .verr_defer(verr_defer),
      .acc_rdata(rdata), .acc_ok(ok), .acc_redirect(red), .acc_redir_off(roff),
      .acc_trap(trp), .acc_trap_class(tcls), .acc_undef(und), .alias_rdata(alias_q),
      .esr_syn(esr), .esr_vld(esr_v), .fsr_syn(fsr), .fsr_vld(fsr_v),
      .dfr_syn(dfr), .dfr_vld(dfr_v));

   virt_err_syndrome #(.HAS_EL2(1'b0)) uut_no_el2 (
      .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
      .cur_el(cur_el), .el2_en(el2_en), .nv_ctl(nv_ctl), .nv_mem(nv_mem),
      .el1_narrow(el1_narrow), .verr_take(verr_take), .verr_defer(verr_defer),
      .acc_rdata(b_rdata), .acc_ok(b_ok), .acc_redirect(b_red), .acc_redir_off(b_roff),
      .acc_trap(b_trp), .acc_trap_class(b_tcls), .acc_undef(b_und), .alias_rdata(b_alias),
      .esr_syn(b_esr), .esr_vld(b_esr_v), .fsr_syn(b_fsr), .fsr_vld(b_fsr_v),
      .dfr_syn(b_dfr), .dfr_vld(b_dfr_v));

   virt_err_syndrome #(.HAS_RAS(1'b0)) uut_no_ras (
      .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_wdata(acc_wdata),
      .cur_el(cur_el), .el2_en(el2_en), .nv_ctl(nv_ctl), .nv_mem(nv_mem),
      .el1_narrow(el1_narrow), .verr_take(verr_take), .verr_defer(verr_defer),
      .acc_rdata(c_rdata), .acc_ok(c_ok), .acc_redirect(c_red), .acc_redir_off(c_roff),
      .acc_trap(c_trp), .acc_trap_class(c_tcls), .acc_undef(c_und), .alias_rdata(c_alias),
      .esr_syn(c_esr), .esr_vld(c_esr_v), .fsr_syn(c_fsr), .fsr_vld(c_fsr_v),
      .dfr_syn(c_dfr), .dfr_vld(c_dfr_v));

   // outcome nibble: {ok, redirect, trap, undef}
   localparam logic [3:0] E_OK = 4'b1000, E_RED = 4'b0100, E_TRP = 4'b0010, E_UND = 4'b0001;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic access(input logic rd, input logic wr, input logic [1:0] el,
                         input logic [63:0] d);
      @(negedge clk);
      acc_rd = rd; acc_wr = wr; cur_el = el; acc_wdata = d;
      #2;
      s_rdata = rdata; s_out = {ok, red, trp, und}; s_off = roff; s_cls = tcls;
      s_b_rdata = b_rdata; s_b_out = {b_ok, b_red, b_trp, b_und};
      s_c_out = {c_ok, c_red, c_trp, c_und};
      @(negedge clk);
      acc_rd = 0; acc_wr = 0;
   endtask

   task automatic read_el2(output logic [63:0] v);
      access(1, 0, 2'd2, '0);
      v = s_rdata;
   endtask

   task automatic t_reset;
      #2;
      chk("R6 idle outcome", {60'd0, ok, red, trp, und}, 64'd0);
      chk("R10 reset esr_vld", {63'd0, esr_v}, 64'd0);
      chk("R11 reset fsr_vld", {63'd0, fsr_v}, 64'd0);
      chk("R12 reset dfr_vld", {63'd0, dfr_v}, 64'd0);
   endtask

   task automatic t_el0;
      el2_en = 1; nv_ctl = 1; nv_mem = 1;
      access(1, 0, 2'd0, '0);
      chk("R1 el0 read", 64'(s_out), 64'(E_UND));
      access(0, 1, 2'd0, 64'hFFFF);
      chk("R1 el0 write", 64'(s_out), 64'(E_UND));
   endtask

   task automatic t_direct_wide;
      logic [63:0] v;
      el1_narrow = 0;
      access(0, 1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R2 el2 write ok", 64'(s_out), 64'(E_OK));
      read_el2(v);
      chk("R7 wide mask all ones", v, 64'h0000_0000_01FF_FFFF);
      access(0, 1, 2'd3, 64'h0123_4567_89AB_CDEF);
      chk("R2 el3 write ok", 64'(s_out), 64'(E_OK));
      access(1, 0, 2'd3, '0);
      chk("R2 el3 read data", s_rdata, 64'h0000_0000_01AB_CDEF);
      #1;
      chk("R9 alias view", 64'(alias_q), 64'h0000_0000_01AB_CDEF);
   endtask

   task automatic t_el1;
      logic [63:0] v;
      el2_en = 1; nv_ctl = 1; nv_mem = 1;
      access(1, 0, 2'd1, '0);
      chk("R3 redirect read", 64'(s_out), 64'(E_RED));
      chk("R3 redirect offset", 64'(s_off), 64'h508);
      access(0, 1, 2'd1, 64'h0000_0000_0000_0055);
      chk("R3 redirect write", 64'(s_out), 64'(E_RED));
      read_el2(v);
      chk("R6 redirected write no store", v, 64'h0000_0000_01AB_CDEF);
      nv_mem = 0;
      access(0, 1, 2'd1, 64'h0000_0000_0000_0077);
      chk("R4 trap write", 64'(s_out), 64'(E_TRP));
      chk("R4 trap class", 64'(s_cls), 64'h18);
      read_el2(v);
      chk("R6 trapped write no store", v, 64'h0000_0000_01AB_CDEF);
      el2_en = 0; nv_ctl = 1; nv_mem = 1;
      access(1, 0, 2'd1, '0);
      chk("R5 el2 disabled undef", 64'(s_out), 64'(E_UND));
      el2_en = 1; nv_ctl = 0; nv_mem = 1;
      access(0, 1, 2'd1, 64'h0000_0000_0000_0011);
      chk("R5 nv clear undef", 64'(s_out), 64'(E_UND));
      read_el2(v);
      chk("R6 undefined write no store", v, 64'h0000_0000_01AB_CDEF);
   endtask

   task automatic t_take_wide;
      el1_narrow = 0;
      @(negedge clk); verr_take = 1;
      @(negedge clk); verr_take = 0;
      #1;
      chk("R10 esr valid", {62'd0, esr_v, fsr_v}, 64'b10);
      chk("R10 esr fields", esr, 64'h0000_0000_01AB_CDEF);
   endtask

   task automatic t_narrow;
      logic [63:0] v;
      el1_narrow = 1;
      access(0, 1, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF);
      read_el2(v);
      chk("R8 narrow mask all ones", v, 64'h0000_0000_0000_D000);
      access(0, 1, 2'd2, 64'hFFFF_FFFF_FFFF_BFFF);
      read_el2(v);
      chk("R8 narrow AET high only", v, 64'h0000_0000_0000_9000);
      @(negedge clk); verr_take = 1;
      @(negedge clk); verr_take = 0;
      #1;
      chk("R11 fsr valid", {62'd0, esr_v, fsr_v}, 64'b01);
      chk("R11 fsr fields", 64'(fsr), 64'h9000);
   endtask

   task automatic t_defer;
      @(negedge clk); verr_defer = 1;
      @(negedge clk); verr_defer = 0;
      #1;
      chk("R12 defer valid narrow", 64'(dfr_v), 64'd1);
      chk("R12 defer narrow fields", dfr, 64'h0000_0000_0000_9000);
      el1_narrow = 0;
      access(0, 1, 2'd3, 64'hF100_0000_0100_0055);
      @(negedge clk); verr_defer = 1;
      @(negedge clk); verr_defer = 0;
      #1;
      chk("R12 defer wide fields", dfr, 64'h0000_0000_0100_0055);
      @(negedge clk); #1;
      chk("R12 defer valid is a pulse", 64'(dfr_v), 64'd0);
   endtask

   task automatic t_params;
      el2_en = 1; nv_ctl = 1; nv_mem = 1;
      access(1, 0, 2'd3, '0);
      chk("R13 no-el2 el3 read ok", 64'(s_b_out), 64'(E_OK));
      chk("R13 no-el2 el3 reads zero", s_b_rdata, 64'd0);
      chk("R13 no-ras el3 read undef", 64'(s_c_out), 64'(E_UND));
      access(0, 1, 2'd2, 64'h1);
      chk("R13 no-el2 el2 undef", 64'(s_b_out), 64'(E_UND));
      chk("R13 no-ras el2 undef", 64'(s_c_out), 64'(E_UND));
      access(1, 0, 2'd1, '0);
      chk("R13 no-el2 el1 undef", 64'(s_b_out), 64'(E_UND));
   endtask

   initial begin
      fork
         begin
            repeat (3) @(posedge clk);
            @(negedge clk); rst_n = 1;
            t_reset();
            t_el0();
            t_direct_wide();
            t_el1();
            t_take_wide();
            t_narrow();
            t_defer();
            t_params();
         end
         begin
            repeat (200000) @(posedge clk);
            fails++;
            $display("FAIL watchdog actual=timeout expected=done");
         end
      join_any
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule